// File: doc/BRIEF.md
# Strobe-Paced Display Counter

This block advances an 8-bit display value at a slow, fixed rate while every flip-flop stays on the one fast input clock. A free-running 8-bit prescaler wraps every 256 fast cycles. A phase bit flips on each wrap, and a registered enable pulse is raised on every second wrap. The pulse is one fast cycle wide and arrives once every 512 cycles, which is the rate of the rising edges of a divide-by-512 clock. The design never builds that clock; it only produces the pulse.

The display counter moves forward by one in the cycle after each pulse and holds its value in all other cycles. Its value drives the segment bus directly. The digit-enable bus is active low and is tied to a constant pattern in which only the top digit is selected. The pulse is also brought out on a port, so that other logic in the same clock domain can use it as its enable.

The block has no data input, so it carries no valid/ready handshake. Every output is a plain level that is valid in every cycle, and nothing can hold the block back.

Top module: `strobe_tick_counter`

## Requirements
- R1: Every register is clocked by `clk` alone. No register uses a logic-derived signal as its clock.
- R2: Consecutive `tick` pulses are exactly 512 `clk` cycles apart (8-bit prescaler, phase bit toggled on each wrap, pulse on every second wrap).
- R3: With reset released before clock edge 1, the first `tick` is high after edge 512, and no pulse occurs earlier.
- R4: `tick` is high for exactly one `clk` cycle each time it fires.
- R5: In the cycle after `tick` is high, `seg_bus` equals its previous value plus one. The counter value drives `seg_bus` with no further decoding.
- R6: In every cycle that does not follow a `tick`, `seg_bus` keeps its value.
- R7: The display counter wraps from 255 to 0 with no saturation.
- R8: `digit_en_n` is active low and always equals 8'h7F, so only bit 7 is asserted.
- R9: A synchronous active-high `rst` clears the prescaler, the phase bit, `tick` and `seg_bus` to 0 on the next edge. The 512-cycle count restarts from the edge where `rst` is seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock (100 MHz in the target); the only clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_bus | output | 8 | Display counter value |
| digit_en_n | output | 8 | Digit enables, active low, constant 8'h7F |
| tick | output | 1 | One-cycle enable pulse, once every 512 cycles |

## Verification
The assertions check four things in every cycle: the single-cycle width of `tick`, the exact 512-cycle spacing (measured by a gap counter in the checker), the hold-or-step rule of `seg_bus` together with its 8-bit wrap, and the constant digit pattern. Only the bench scenarios can show the following: where the first pulse lands after reset, that the counter comes back through 0 after a full 256 pulses, and that a reset asserted partway through a period restarts both the phase and the count.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int unsigned PRE_W_DEF   = 8;
  localparam int unsigned CNT_W_DEF   = 8;
  localparam int unsigned DIGITS_DEF  = 8;
  localparam int unsigned ACTIVE_DEF  = 7;

  typedef struct packed {
    logic wrap;
    logic phase;
  } pace_t;
endpackage

// File: rtl/stc_prescaler.sv
module stc_prescaler #(
  parameter int unsigned WIDTH = stc_pkg::PRE_W_DEF
) (
  input  logic clk,
  input  logic rst,
  output logic wrap
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == TOP) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wrap = (cnt_q == TOP);
endmodule

// File: rtl/stc_phase_strobe.sv
module stc_phase_strobe (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  output logic tick
);
  stc_pkg::pace_t st_q;
  logic           tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      st_q.wrap <= wrap;
      if (wrap) begin
        st_q.phase <= ~st_q.phase;
      end
      tick_q <= wrap & st_q.phase;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/stc_step_counter.sv
module stc_step_counter #(
  parameter int unsigned WIDTH = stc_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else if (step) begin
      val_q <= val_q + 1'b1;
    end
  end

  assign value = val_q;
endmodule

// File: rtl/strobe_tick_counter.sv
module strobe_tick_counter #(
  parameter int unsigned PRE_W  = stc_pkg::PRE_W_DEF,
  parameter int unsigned CNT_W  = stc_pkg::CNT_W_DEF,
  parameter int unsigned DIGITS = stc_pkg::DIGITS_DEF,
  parameter int unsigned ACTIVE = stc_pkg::ACTIVE_DEF
) (
  input  logic              clk,
  input  logic              rst,
  output logic [CNT_W-1:0]  seg_bus,
  output logic [DIGITS-1:0] digit_en_n,
  output logic              tick
);
  logic wrap;

  stc_prescaler #(.WIDTH(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .wrap (wrap)
  );

  stc_phase_strobe u_phs (
    .clk  (clk),
    .rst  (rst),
    .wrap (wrap),
    .tick (tick)
  );

  stc_step_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (tick),
    .value (seg_bus)
  );

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    if (i == ACTIVE) begin : g_on
      assign digit_en_n[i] = 1'b0;
    end else begin : g_off
      assign digit_en_n[i] = 1'b1;
    end
  end
endmodule

// File: rtl/strobe_tick_counter_chk.sv
module strobe_tick_counter_chk #(
  parameter int unsigned PRE_W  = stc_pkg::PRE_W_DEF,
  parameter int unsigned CNT_W  = stc_pkg::CNT_W_DEF,
  parameter int unsigned DIGITS = stc_pkg::DIGITS_DEF,
  parameter int unsigned ACTIVE = stc_pkg::ACTIVE_DEF
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  seg_bus,
  input logic [DIGITS-1:0] digit_en_n,
  input logic              tick
);
  localparam int unsigned PERIOD = 2 ** (PRE_W + 1);
  localparam int unsigned GAP_W  = PRE_W + 2;
  localparam logic [DIGITS-1:0] PATTERN = ~(DIGITS'(1) << ACTIVE);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (tick) begin
      gap_q <= GAP_W'(1);
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R4
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |-> gap_q == GAP_W'(PERIOD)); // R2
  AST_TICK_NOT_LATE: assert property (@(posedge clk) disable iff (rst)
    gap_q == GAP_W'(PERIOD) |-> tick); // R3
  AST_SEG_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(tick) && !$past(rst)) |-> seg_bus == CNT_W'($past(seg_bus) + 1'b1)); // R5
  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(rst)) |-> $stable(seg_bus)); // R6
  AST_DIGIT_CONST: assert property (@(posedge clk) disable iff (rst)
    digit_en_n == PATTERN); // R8
endmodule

bind strobe_tick_counter strobe_tick_counter_chk #(
  .PRE_W(PRE_W), .CNT_W(CNT_W), .DIGITS(DIGITS), .ACTIVE(ACTIVE)
) u_chk (
  .clk(clk), .rst(rst), .seg_bus(seg_bus), .digit_en_n(digit_en_n), .tick(tick)
);

// File: tb/strobe_tick_counter_test.sv
module strobe_tick_counter_test;
  localparam int PERIOD = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] seg_bus;
  logic [7:0] digit_en_n;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int seen = 0;
  logic prev_tick = 1'b0;
  logic expect_step = 1'b0;
  logic [7:0] prev_seg = 8'h00;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  strobe_tick_counter uut (
    .clk(clk), .rst(rst), .seg_bus(seg_bus), .digit_en_n(digit_en_n), .tick(tick)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: expected tick edge indices within a horizon
  task automatic plan_ticks(input int horizon);
    exp_q.delete();
    for (int k = PERIOD; k <= horizon; k += PERIOD) exp_q.push_back(k);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst) begin
      seen = 0;
      prev_tick = 1'b0;
      expect_step = 1'b0;
      prev_seg = 8'h00;
    end else if (!done) begin
      if (expect_step) begin
        check(seg_bus == 8'(prev_seg + 8'd1), "R5/R7 step", seg_bus, 8'(prev_seg + 8'd1));
      end else if (seg_bus != prev_seg) begin
        check(1'b0, "R6 hold", seg_bus, prev_seg);
      end
      if (digit_en_n != 8'h7F) check(1'b0, "R8 digit", digit_en_n, 8'h7F);
      if (tick) begin
        check(!prev_tick, "R4 width", prev_tick, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R3 unexpected tick", cyc, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, (seen == 0) ? "R3 first tick" : "R2 spacing", cyc, e);
        end
        check(seg_bus == 8'(seen), "R5 value at tick", seg_bus, 8'(seen));
        seen++;
      end
      prev_tick = tick;
      expect_step = tick;
      prev_seg = seg_bus;
    end
  end

  initial begin
    int wrap_horizon;
    wrap_horizon = PERIOD * 257 + 5;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(seg_bus == 8'h00, "R9 reset seg", seg_bus, 0);
    check(tick == 1'b0, "R9 reset tick", tick, 0);
    check(digit_en_n == 8'h7F, "R8 reset digit", digit_en_n, 8'h7F);
    plan_ticks(wrap_horizon);
    rst = 1'b0;
    while (cyc < wrap_horizon) @(negedge clk);
    check(exp_q.size() == 0, "R2 all ticks seen", exp_q.size(), 0);
    check(seen == 257, "R7 tick count through wrap", seen, 257);
    check(seg_bus == 8'd1, "R7 wrapped value", seg_bus, 1);
    // reset part-way through a period
    repeat (300) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(seg_bus == 8'h00, "R9 mid-run seg", seg_bus, 0);
    check(tick == 1'b0, "R9 mid-run tick", tick, 0);
    plan_ticks(PERIOD * 2 + 40);
    rst = 1'b0;
    @(negedge clk);
    while (cyc < PERIOD * 2 + 40) @(negedge clk);
    check(exp_q.size() == 0, "R9 restart ticks", exp_q.size(), 0);
    check(seen == 2, "R9 restart count", seen, 2);
    check(seg_bus == 8'd2, "R1/R5 final value", seg_bus, 2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule